// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Immediate Forms

This block is the integer execute stage of a 64-bit RISC pipeline. Each cycle, the decode stage can hand it one operation. The operation carries an operation code, two register operands with their source indices, an immediate that decode has already sign- or zero-extended to 64 bits, a 2-bit shift field, the address of the current instruction and a destination index. On the next rising clock edge the unit registers a 64-bit result, together with a valid flag, the destination index, a register-file write enable and an illegal-operation flag.

The unit covers these operation families:
- add and subtract, in word and doubleword forms
- signed and unsigned set-less-than
- the full bitwise set, including NOR, AND-NOT and OR-NOT
- scaled shift-and-add
- upper-immediate loads that build or patch constants
- PC-relative address forms, including a page-aligned variant

Multiply, divide, decode, the register file and exception handling are outside this block. Source index 0 always reads as zero, and a result aimed at index 0 is never written.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is asserted, and right after it, `res_valid`, `res_wen` and `res_illegal` are 0 and `res_data` is 0.
- R2: An operation presented with `in_valid`=1 appears on the outputs after exactly one rising edge, with `res_valid`=1. A cycle with `in_valid`=0 gives `res_valid`=0 and leaves `res_data` unchanged.
- R3: When a source index is 0, that operand is taken as zero, whatever value is driven on its data input.
- R4: `res_wen` is 1 only for a valid, legal operation whose destination index is nonzero. `res_idx` carries the destination index.
- R5: Operation codes 30 to 63 are illegal. They set `res_illegal`=1 and `res_wen`=0.
- R6: Word add (code 0), word subtract (2) and word add-immediate (17) operate on bits 31:0 and sign-extend the 32-bit result to 64 bits.
- R7: Doubleword add (1), doubleword subtract (3) and doubleword add-immediate (18) produce the full 64-bit result, modulo 2^64.
- R8: Set-less-than writes 1 or 0. Code 4 is signed A<B, code 5 is unsigned A<B, code 6 is signed A<imm and code 7 is unsigned A<imm.
- R9: The bitwise codes are: 8 AND, 9 OR, 10 XOR, 11 NOR, 12 A&~B, 13 A|~B, 14 A&imm, 15 A|imm, 16 A^imm.
- R10: Shift-and-add computes (A << (sa+1)) + B, a shift of 1 to 4. Code 19 sign-extends the low 32 bits, code 20 zero-extends them, and code 21 keeps all 64 bits.
- R11: The upper-immediate loads are:
  - code 22 gives imm<<12;
  - code 23 gives {imm[31:0], A[31:0]}, where A carries the current destination value;
  - code 24 gives {imm[11:0], A[51:0]}.
- R12: The PC-relative codes are: 25 gives pc+(imm<<2), 26 gives pc+(imm<<12), 27 gives pc+(imm<<18), and 28 gives pc+(imm<<12) with bits 11:0 cleared.
- R13: Code 29 computes A + (imm<<16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 6 | Operation code |
| in_src_a_idx | input | 5 | Register index of operand A (0 reads zero) |
| in_src_b_idx | input | 5 | Register index of operand B (0 reads zero) |
| in_dst_idx | input | 5 | Destination register index |
| in_src_a | input | 64 | Operand A value |
| in_src_b | input | 64 | Operand B value |
| in_imm | input | 64 | Immediate, already extended by decode |
| in_sa | input | 2 | Shift field for shift-and-add |
| in_pc | input | 64 | Address of the current instruction |
| res_valid | output | 1 | Registered result is valid |
| res_wen | output | 1 | Write the result to the register file |
| res_illegal | output | 1 | The operation code was not recognised |
| res_idx | output | 5 | Destination index of the result |
| res_data | output | 64 | Registered 64-bit result |

## Verification
The stage holds no state beyond its single output register. A wrong select or a wrong extension therefore shows up in `res_data` on the very next edge, for the one operation that caused it, and never leaks into later operations. A wrong gating term shows up in `res_wen` or `res_illegal` in that same cycle, typically for destination index 0 or for an unused code. Comparing every output after every operation against a model written from the requirements therefore localises a fault to one operation code and one cycle.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_W    = 6'd0,
    OP_ADD_D    = 6'd1,
    OP_SUB_W    = 6'd2,
    OP_SUB_D    = 6'd3,
    OP_SLT      = 6'd4,
    OP_SLTU     = 6'd5,
    OP_SLT_I    = 6'd6,
    OP_SLTU_I   = 6'd7,
    OP_AND      = 6'd8,
    OP_OR       = 6'd9,
    OP_XOR      = 6'd10,
    OP_NOR      = 6'd11,
    OP_ANDNOT   = 6'd12,
    OP_ORNOT    = 6'd13,
    OP_AND_I    = 6'd14,
    OP_OR_I     = 6'd15,
    OP_XOR_I    = 6'd16,
    OP_ADD_WI   = 6'd17,
    OP_ADD_DI   = 6'd18,
    OP_SHADD_W  = 6'd19,
    OP_SHADD_WU = 6'd20,
    OP_SHADD_D  = 6'd21,
    OP_UPR12    = 6'd22,
    OP_UPR32    = 6'd23,
    OP_UPR52    = 6'd24,
    OP_PCREL2   = 6'd25,
    OP_PCREL12  = 6'd26,
    OP_PCREL18  = 6'd27,
    OP_PCPAGE   = 6'd28,
    OP_ADDHI16  = 6'd29
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_ADDHI16;

endpackage

// File: rtl/exec_src_gate.sv
module exec_src_gate #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  raw,
  output logic [XLEN-1:0]  val
);
  // index 0 is the hard-wired zero register
  always_comb begin
    val = (idx == '0) ? '0 : raw;
  end
endmodule

// File: rtl/exec_arith.sv
module exec_arith
  import exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  input  logic [1:0]      sa,
  output logic            hit,
  output logic [XLEN-1:0] result
);
  localparam int WLEN = XLEN / 2;
  localparam int HI16 = 16;

  logic [XLEN-1:0] sum_ab, sum_ai, diff_ab, shadd, addhi;
  logic [2:0]      shamt;
  logic            lt_s_ab, lt_u_ab, lt_s_ai, lt_u_ai;

  function automatic logic [XLEN-1:0] sext_w(input logic [XLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v[WLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] zext_w(input logic [XLEN-1:0] v);
    return {{(XLEN-WLEN){1'b0}}, v[WLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] flag(input logic f);
    return {{(XLEN-1){1'b0}}, f};
  endfunction

  always_comb begin
    shamt   = {1'b0, sa} + 3'd1;
    sum_ab  = a + b;
    sum_ai  = a + imm;
    diff_ab = a - b;
    shadd   = (a << shamt) + b;
    addhi   = a + (imm << HI16);
    lt_s_ab = $signed(a) < $signed(b);
    lt_u_ab = a < b;
    lt_s_ai = $signed(a) < $signed(imm);
    lt_u_ai = a < imm;
  end

  always_comb begin
    hit    = 1'b1;
    result = '0;
    case (op)
      OP_ADD_W:    result = sext_w(sum_ab);
      OP_ADD_D:    result = sum_ab;
      OP_SUB_W:    result = sext_w(diff_ab);
      OP_SUB_D:    result = diff_ab;
      OP_ADD_WI:   result = sext_w(sum_ai);
      OP_ADD_DI:   result = sum_ai;
      OP_SLT:      result = flag(lt_s_ab);
      OP_SLTU:     result = flag(lt_u_ab);
      OP_SLT_I:    result = flag(lt_s_ai);
      OP_SLTU_I:   result = flag(lt_u_ai);
      OP_SHADD_W:  result = sext_w(shadd);
      OP_SHADD_WU: result = zext_w(shadd);
      OP_SHADD_D:  result = shadd;
      OP_ADDHI16:  result = addhi;
      default:     hit    = 1'b0;
    endcase
  end

  // compare results are a single flag bit
  always_comb begin
    if (hit && (op == OP_SLT || op == OP_SLTU || op == OP_SLT_I || op == OP_SLTU_I))
      assert_slt_flag_R8: assert (result[XLEN-1:1] == '0);
  end
endmodule

// File: rtl/exec_logic.sv
module exec_logic
  import exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  output logic            hit,
  output logic [XLEN-1:0] result
);
  always_comb begin
    hit    = 1'b1;
    result = '0;
    case (op)
      OP_AND:    result = a & b;
      OP_OR:     result = a | b;
      OP_XOR:    result = a ^ b;
      OP_NOR:    result = ~(a | b);
      OP_ANDNOT: result = a & ~b;
      OP_ORNOT:  result = a | ~b;
      OP_AND_I:  result = a & imm;
      OP_OR_I:   result = a | imm;
      OP_XOR_I:  result = a ^ imm;
      default:   hit    = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_pcimm.sv
module exec_pcimm
  import exec_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PAGE_SH  = 12,
  parameter int TOP_FLD  = 12
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] pc,
  output logic            hit,
  output logic [XLEN-1:0] result
);
  localparam int WLEN   = XLEN / 2;
  localparam int KEEP   = XLEN - TOP_FLD;
  localparam int SH_WRD = 2;
  localparam int SH_BIG = 18;
  localparam logic [XLEN-1:0] PAGE_MASK = {{(XLEN-PAGE_SH){1'b1}}, {PAGE_SH{1'b0}}};

  logic [XLEN-1:0] pc_page_sum;

  always_comb begin
    pc_page_sum = pc + (imm << PAGE_SH);
  end

  always_comb begin
    hit    = 1'b1;
    result = '0;
    case (op)
      OP_UPR12:   result = imm << PAGE_SH;
      OP_UPR32:   result = {imm[WLEN-1:0], a[WLEN-1:0]};
      OP_UPR52:   result = {imm[TOP_FLD-1:0], a[KEEP-1:0]};
      OP_PCREL2:  result = pc + (imm << SH_WRD);
      OP_PCREL12: result = pc_page_sum;
      OP_PCREL18: result = pc + (imm << SH_BIG);
      OP_PCPAGE:  result = pc_page_sum & PAGE_MASK;
      default:    hit    = 1'b0;
    endcase
  end

  always_comb begin
    if (op == OP_PCPAGE)
      assert_page_aligned_R12: assert (result[PAGE_SH-1:0] == '0);
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic [IDX_W-1:0] in_src_a_idx,
  input  logic [IDX_W-1:0] in_src_b_idx,
  input  logic [IDX_W-1:0] in_dst_idx,
  input  logic [XLEN-1:0]  in_src_a,
  input  logic [XLEN-1:0]  in_src_b,
  input  logic [XLEN-1:0]  in_imm,
  input  logic [1:0]       in_sa,
  input  logic [XLEN-1:0]  in_pc,
  output logic             res_valid,
  output logic             res_wen,
  output logic             res_illegal,
  output logic [IDX_W-1:0] res_idx,
  output logic [XLEN-1:0]  res_data
);
  localparam int NSRC  = 2;
  localparam int NUNIT = 3;
  localparam int WLEN  = XLEN / 2;

  logic [NSRC-1:0][IDX_W-1:0] src_idx;
  logic [NSRC-1:0][XLEN-1:0]  src_raw, src_val;
  logic [NUNIT-1:0]           unit_hit;
  logic [NUNIT-1:0][XLEN-1:0] unit_res;

  assign src_idx = {in_src_b_idx, in_src_a_idx};
  assign src_raw = {in_src_b, in_src_a};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    exec_src_gate #(.XLEN(XLEN), .IDX_W(IDX_W)) u_gate (
      .idx (src_idx[g]),
      .raw (src_raw[g]),
      .val (src_val[g])
    );
  end

  exec_arith #(.XLEN(XLEN)) u_arith (
    .op(in_op), .a(src_val[0]), .b(src_val[1]), .imm(in_imm), .sa(in_sa),
    .hit(unit_hit[0]), .result(unit_res[0])
  );

  exec_logic #(.XLEN(XLEN)) u_logic (
    .op(in_op), .a(src_val[0]), .b(src_val[1]), .imm(in_imm),
    .hit(unit_hit[1]), .result(unit_res[1])
  );

  exec_pcimm #(.XLEN(XLEN)) u_pcimm (
    .op(in_op), .a(src_val[0]), .imm(in_imm), .pc(in_pc),
    .hit(unit_hit[2]), .result(unit_res[2])
  );

  // next-state
  logic             nxt_valid, nxt_wen, nxt_illegal, ld_en;
  logic [IDX_W-1:0] nxt_idx;
  logic [XLEN-1:0]  nxt_data;

  always_comb begin
    nxt_data = '0;
    for (int u = 0; u < NUNIT; u++) nxt_data = nxt_data | unit_res[u];
    nxt_illegal = ~|unit_hit;
    nxt_valid   = in_valid;
    nxt_wen     = in_valid & ~nxt_illegal & (in_dst_idx != '0);
    nxt_idx     = in_dst_idx;
    ld_en       = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_wen     <= 1'b0;
      res_illegal <= 1'b0;
      res_idx     <= '0;
      res_data    <= '0;
    end else begin
      res_valid <= nxt_valid;
      res_wen   <= nxt_wen;
      if (ld_en) begin
        res_illegal <= nxt_illegal;
        res_idx     <= nxt_idx;
        res_data    <= nxt_data;
      end
    end
  end

  assert_one_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_hit));
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_data)));
  assert_no_zero_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_wen |-> (res_idx != '0 && res_valid && !res_illegal));
  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op > OP_LAST) |=> (res_illegal && !res_wen));
  assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_ADD_W || in_op == OP_SUB_W || in_op == OP_ADD_WI))
    |=> (res_data[XLEN-1:WLEN-1] == {(WLEN+1){res_data[WLEN-1]}}));
  assert_word_zext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_SHADD_WU) |=> (res_data[XLEN-1:WLEN] == '0));
endmodule

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_op = '0;
  logic [4:0]  in_src_a_idx = '0, in_src_b_idx = '0, in_dst_idx = '0;
  logic [63:0] in_src_a = '0, in_src_b = '0, in_imm = '0, in_pc = '0;
  logic [1:0]  in_sa = '0;
  logic        res_valid, res_wen, res_illegal;
  logic [4:0]  res_idx;
  logic [63:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  int_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src_a_idx(in_src_a_idx), .in_src_b_idx(in_src_b_idx), .in_dst_idx(in_dst_idx),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm), .in_sa(in_sa),
    .in_pc(in_pc), .res_valid(res_valid), .res_wen(res_wen),
    .res_illegal(res_illegal), .res_idx(res_idx), .res_data(res_data)
  );

  function automatic logic [63:0] sx32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [64:0] model(input int op, input logic [63:0] a, b, imm,
                                        input logic [1:0] sa, input logic [63:0] pc);
    logic [63:0] t;
    t = (a << (sa + 1)) + b;
    case (op)
      0:  return {1'b0, sx32(a + b)};
      1:  return {1'b0, a + b};
      2:  return {1'b0, sx32(a - b)};
      3:  return {1'b0, a - b};
      4:  return {1'b0, 63'd0, $signed(a) < $signed(b)};
      5:  return {1'b0, 63'd0, a < b};
      6:  return {1'b0, 63'd0, $signed(a) < $signed(imm)};
      7:  return {1'b0, 63'd0, a < imm};
      8:  return {1'b0, a & b};
      9:  return {1'b0, a | b};
      10: return {1'b0, a ^ b};
      11: return {1'b0, ~(a | b)};
      12: return {1'b0, a & ~b};
      13: return {1'b0, a | ~b};
      14: return {1'b0, a & imm};
      15: return {1'b0, a | imm};
      16: return {1'b0, a ^ imm};
      17: return {1'b0, sx32(a + imm)};
      18: return {1'b0, a + imm};
      19: return {1'b0, sx32(t)};
      20: return {1'b0, 32'd0, t[31:0]};
      21: return {1'b0, t};
      22: return {1'b0, imm << 12};
      23: return {1'b0, imm[31:0], a[31:0]};
      24: return {1'b0, imm[11:0], a[51:0]};
      25: return {1'b0, pc + (imm << 2)};
      26: return {1'b0, pc + (imm << 12)};
      27: return {1'b0, pc + (imm << 18)};
      28: return {1'b0, (pc + (imm << 12)) & ~64'hfff};
      29: return {1'b0, a + (imm << 16)};
      default: return {1'b1, 64'd0};
    endcase
  endfunction

  function automatic string tag_of(input int op);
    if (op <= 3 || op == 17 || op == 18) return ((op == 0 || op == 2 || op == 17) ? "R6" : "R7");
    if (op <= 7)  return "R8";
    if (op <= 16) return "R9";
    if (op <= 21) return "R10";
    if (op <= 24) return "R11";
    if (op <= 28) return "R12";
    if (op == 29) return "R13";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int op, input logic [63:0] a, b, imm,
                     input logic [1:0] sa, input logic [63:0] pc,
                     input logic [4:0] ia, ib, rd, input string extra);
    logic [64:0] e;
    logic [63:0] ea, eb;
    @(negedge clk);
    in_valid = 1'b1; in_op = 6'(op); in_src_a = a; in_src_b = b; in_imm = imm;
    in_sa = sa; in_pc = pc; in_src_a_idx = ia; in_src_b_idx = ib; in_dst_idx = rd;
    ea = (ia == 0) ? 64'd0 : a;   // R3
    eb = (ib == 0) ? 64'd0 : b;
    e  = model(op, ea, eb, imm, sa, pc);
    @(posedge clk); #1;
    chk(res_valid === 1'b1, "R2 valid", {63'd0, res_valid}, 64'd1);
    chk(res_illegal === e[64], "R5 illegal", {63'd0, res_illegal}, {63'd0, e[64]});
    chk(res_wen === (!e[64] && rd != 0), "R4 wen", {63'd0, res_wen},
        {63'd0, (!e[64] && rd != 0)});
    chk(res_idx === rd, "R4 idx", {59'd0, res_idx}, {59'd0, rd});
    if (!e[64])
      chk(res_data === e[63:0], {tag_of(op), extra}, res_data, e[63:0]);
  endtask

  task automatic idle_check();
    logic [63:0] held;
    @(negedge clk);
    held = res_data;
    in_valid = 1'b0;
    in_op = 6'd1; in_src_a = 64'hdead; in_src_a_idx = 5'd1;
    @(posedge clk); #1;
    chk(res_valid === 1'b0, "R2 idle valid", {63'd0, res_valid}, 64'd0);
    chk(res_wen === 1'b0, "R4 idle wen", {63'd0, res_wen}, 64'd0);
    chk(res_data === held, "R2 idle hold", res_data, held);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2468));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(res_valid === 1'b0, "R1 valid", {63'd0, res_valid}, 64'd0);
    chk(res_wen === 1'b0, "R1 wen", {63'd0, res_wen}, 64'd0);
    chk(res_illegal === 1'b0, "R1 illegal", {63'd0, res_illegal}, 64'd0);
    chk(res_data === 64'd0, "R1 data", res_data, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(res_valid === 1'b0 && res_data === 64'd0, "R1 after release", res_data, 64'd0);

    // directed corners
    run(0, 64'h7fff_ffff, 64'd1, 0, 0, 0, 1, 2, 3, " word add overflow");
    run(2, 64'h0, 64'd1, 0, 0, 0, 1, 2, 3, " word sub wrap");
    run(17, 64'h1_0000_0005, 0, -64'sd10, 0, 0, 1, 2, 3, " word addi");
    run(3, 64'h0, 64'd1, 0, 0, 0, 1, 2, 3, " dword sub wrap");
    run(4, -64'sd1, 64'd1, 0, 0, 0, 1, 2, 3, " signed lt");
    run(5, -64'sd1, 64'd1, 0, 0, 0, 1, 2, 3, " unsigned lt");
    run(7, 64'd5, 0, -64'sd1, 0, 0, 1, 2, 3, " unsigned lt imm");
    run(12, 64'hff00, 64'h0f0f, 0, 0, 0, 1, 2, 3, " andnot");
    run(13, 64'h0, 64'h0f0f, 0, 0, 0, 1, 2, 3, " ornot");
    run(19, 64'h0800_0000, 64'd0, 0, 2'd3, 0, 1, 2, 3, " shadd word sign");
    run(20, 64'h1000_0000, 64'd7, 0, 2'd3, 0, 1, 2, 3, " shadd uword");
    run(21, 64'h1, 64'd1, 0, 2'd0, 0, 1, 2, 3, " shadd dword min shift");
    run(23, 64'h1111_2222_3333_4444, 0, sx32(64'hfff8_0000), 0, 0, 1, 2, 3, " upper32");
    run(24, 64'h1111_2222_3333_4444, 0, 64'habc, 0, 0, 1, 2, 3, " upper52");
    run(28, 0, 0, 64'd1, 0, 64'h1234_5fff, 1, 2, 3, " page");
    run(27, 0, 0, -64'sd1, 0, 64'h4_0000_0000, 1, 2, 3, " pc18 neg");
    run(29, 64'h10, 0, -64'sd2, 0, 0, 1, 2, 3, " addhi16");
    run(45, 64'h1, 64'h2, 0, 0, 0, 1, 2, 3, " illegal");
    run(63, 64'h1, 64'h2, 0, 0, 0, 1, 2, 0, " illegal top code");
    run(1, 64'h55, 64'h66, 0, 0, 0, 1, 2, 0, " R4 rd zero");
    run(1, 64'h55, 64'h66, 0, 0, 0, 0, 0, 4, " R3 both zero");
    run(9, 64'h55, 64'h66, 0, 0, 0, 3, 0, 4, " R3 b zero");
    idle_check();

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [4:0] ia, ib, rd;
      op = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 30);
      ia = 5'($urandom % 8); ib = 5'($urandom % 8); rd = 5'($urandom % 6);
      run(op, {$urandom, $urandom}, {$urandom, $urandom},
          ($urandom % 2) ? {{44{1'b1}}, 20'($urandom)} : {44'd0, 20'($urandom)},
          2'($urandom), {$urandom, $urandom}, ia, ib, rd, " random");
      if (i % 50 == 0) idle_check();
    end
    idle_check();
    finish_run();
  end
endmodule